// File: doc/BRIEF.md
# Timer Freeze Controller

This block holds one freeze flag for each of five on-chip timing agents and drives a freeze enable for each of them. The agents are a wakeup timer, a software timer, the radio master clock, a watchdog and a DMA engine. Software freezes agents by writing ones to a set register and releases them by writing ones to a clear register. A zero bit in either write leaves that agent alone, so different software contexts can change their own agents without a read-modify-write.

A debug-halt input can also force agents to freeze. A debug-freeze enable bit selects how. When the bit is 1, a halt freezes every agent. When it is 0, a halt leaves each agent at its stored flag, except the watchdog, which a halt always freezes. A freeze request for the watchdog is refused while the watchdog runs in NMI-reset mode.

The block sits behind a simple 16-bit register port with one write or read per cycle.

Top module: `frz_ctrl`

## Requirements
- R1: Bit i of the stored freeze state and of `freeze_o` belongs to one agent: bit 0 wakeup timer, bit 1 software timer, bit 2 radio master clock, bit 3 watchdog, bit 4 DMA.
- R2: A write to byte offset 0 sets, from the next cycle, the stored flag of every bit 4..0 that is written as 1. Bits written as 0 keep their flag.
- R3: A write to byte offset 2 clears, from the next cycle, the stored flag of every bit 4..0 that is written as 1. Bits written as 0 keep their flag. Where a set and a clear of the same bit coincide, the clear wins.
- R4: `rdata_o` returns the stored freeze state in bits 4..0, with bits 15..5 zero, when `addr_i` is 0 or 2. It returns the debug-freeze enable in bit 0 at offset 4. It returns 0 at any other offset. A write to any other offset changes nothing.
- R5: The debug-freeze enable resets to 1. Bit 0 of a write to offset 4 loads it from the next cycle.
- R6: While `halt_i` is 1 and the debug-freeze enable is 1, `freeze_o` is 5'b11111 in the same cycle.
- R7: While `halt_i` is 1 and the debug-freeze enable is 0, `freeze_o` equals the stored state with bit 3 forced to 1, in the same cycle.
- R8: Bit 3 of a set-register write takes effect only while `wdog_nmi_mode_i` is 0. Otherwise bit 3 of that write is ignored.
- R9: Reset clears all stored freeze flags, so `freeze_o` is 0 after reset while `halt_i` is 0.
- R10: While `halt_i` is 0, `freeze_o` equals the stored freeze state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| halt_i | input | 1 | CPU halted in debug |
| wdog_nmi_mode_i | input | 1 | Watchdog is in NMI-reset mode |
| freeze_o | output | 5 | Freeze enables, one per agent |

## Verification
A register write lands on the clock edge that samples it. The bench therefore checks both `freeze_o` and the read-back 2 ns after that edge, with the write inputs still held. Halt effects and the read mux are combinational, so a change to `halt_i` or `addr_i` shows in the sample taken after the same edge. The table walks set, clear, the zero-bit cases, the watchdog NMI gate and both halt modes. Directed tests then cover the reset values, each agent bit on its own, and a reset applied while agents are frozen.

// File: rtl/frz_pkg.sv
package frz_pkg;
  localparam int unsigned NUM_AGENTS  = 5;
  localparam int unsigned AGENT_WKUP  = 0;
  localparam int unsigned AGENT_SWTIM = 1;
  localparam int unsigned AGENT_RADIO = 2;
  localparam int unsigned AGENT_WDOG  = 3;
  localparam int unsigned AGENT_DMA   = 4;
  localparam int unsigned REG_DATA_W  = 16;
  localparam int unsigned REG_ADDR_W  = 4;
  localparam int unsigned OFS_SET     = 0;
  localparam int unsigned OFS_CLR     = 2;
  localparam int unsigned OFS_DBG     = 4;
endpackage

// File: rtl/frz_regif.sv
module frz_regif #(
  parameter int unsigned DATA_W  = frz_pkg::REG_DATA_W,
  parameter int unsigned ADDR_W  = frz_pkg::REG_ADDR_W,
  parameter int unsigned N       = frz_pkg::NUM_AGENTS,
  parameter int unsigned SET_OFS = frz_pkg::OFS_SET,
  parameter int unsigned CLR_OFS = frz_pkg::OFS_CLR,
  parameter int unsigned DBG_OFS = frz_pkg::OFS_DBG
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      state_i,
  input  logic              dbg_en_i,
  output logic [N-1:0]      set_req_o,
  output logic [N-1:0]      clr_req_o,
  output logic              dbg_we_o,
  output logic              dbg_wd_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(SET_OFS);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(CLR_OFS);
  localparam logic [ADDR_W-1:0] A_DBG = ADDR_W'(DBG_OFS);

  logic hit_set, hit_clr, hit_dbg;
  logic unused_wdata_hi;

  assign hit_set = (addr_i == A_SET);
  assign hit_clr = (addr_i == A_CLR);
  assign hit_dbg = (addr_i == A_DBG);

  assign set_req_o = (wr_en_i && hit_set) ? wdata_i[N-1:0] : '0;
  assign clr_req_o = (wr_en_i && hit_clr) ? wdata_i[N-1:0] : '0;
  assign dbg_we_o  = wr_en_i && hit_dbg;
  assign dbg_wd_o  = wdata_i[0];
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:N];

  always_comb begin
    rdata_o = '0;
    if (hit_set || hit_clr) rdata_o[N-1:0] = state_i;
    else if (hit_dbg)       rdata_o[0]     = dbg_en_i;
  end
endmodule

// File: rtl/frz_cell.sv
module frz_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;   // clear has priority
    else if (set_i) q_o <= 1'b1;
  end

  AST_SET_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> q_o); // R2
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !q_o); // R3
  AST_ZERO_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(q_o)); // R2
endmodule

// File: rtl/frz_halt_ovr.sv
module frz_halt_ovr #(
  parameter int unsigned N        = frz_pkg::NUM_AGENTS,
  parameter int unsigned WDOG_IDX = frz_pkg::AGENT_WDOG,
  parameter logic        DBG_RST  = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dbg_we_i,
  input  logic         dbg_wd_i,
  input  logic         halt_i,
  input  logic [N-1:0] state_i,
  output logic         dbg_en_o,
  output logic [N-1:0] freeze_o
);
  localparam logic [N-1:0] WDOG_MASK = N'(1) << WDOG_IDX;

  logic [N-1:0] force_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dbg_en_o <= DBG_RST;
    else if (dbg_we_i) dbg_en_o <= dbg_wd_i;
  end

  always_comb begin
    if (!halt_i)       force_mask = '0;
    else if (dbg_en_o) force_mask = '1;
    else               force_mask = WDOG_MASK;
  end

  assign freeze_o = state_i | force_mask;

  AST_DBG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_we_i |=> (dbg_en_o == $past(dbg_wd_i))); // R5
  AST_HALT_WDOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> freeze_o[WDOG_IDX]); // R7
endmodule

// File: rtl/frz_ctrl.sv
module frz_ctrl #(
  parameter int unsigned DATA_W   = frz_pkg::REG_DATA_W,
  parameter int unsigned ADDR_W   = frz_pkg::REG_ADDR_W,
  parameter int unsigned N        = frz_pkg::NUM_AGENTS,
  parameter int unsigned WDOG_IDX = frz_pkg::AGENT_WDOG,
  parameter int unsigned SET_OFS  = frz_pkg::OFS_SET,
  parameter int unsigned CLR_OFS  = frz_pkg::OFS_CLR,
  parameter int unsigned DBG_OFS  = frz_pkg::OFS_DBG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              halt_i,
  input  logic              wdog_nmi_mode_i,
  output logic [N-1:0]      freeze_o
);
  logic [N-1:0] state_q;
  logic [N-1:0] set_req, clr_req, set_gated;
  logic         dbg_we, dbg_wd, dbg_en;

  frz_regif #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N(N),
    .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS), .DBG_OFS(DBG_OFS)
  ) u_regif (
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .state_i  (state_q),
    .dbg_en_i (dbg_en),
    .set_req_o(set_req),
    .clr_req_o(clr_req),
    .dbg_we_o (dbg_we),
    .dbg_wd_o (dbg_wd),
    .rdata_o  (rdata_o)
  );

  for (genvar g = 0; g < N; g++) begin : g_agent
    if (g == WDOG_IDX) begin : g_wdog
      // NMI-reset mode blocks a watchdog freeze request
      assign set_gated[g] = set_req[g] & ~wdog_nmi_mode_i;
    end else begin : g_plain
      assign set_gated[g] = set_req[g];
    end
    frz_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_gated[g]),
      .clr_i (clr_req[g]),
      .q_o   (state_q[g])
    );
  end

  frz_halt_ovr #(.N(N), .WDOG_IDX(WDOG_IDX), .DBG_RST(1'b1)) u_ovr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dbg_we_i(dbg_we),
    .dbg_wd_i(dbg_wd),
    .halt_i  (halt_i),
    .state_i (state_q),
    .dbg_en_o(dbg_en),
    .freeze_o(freeze_o)
  );

  AST_WDOG_NMI_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(SET_OFS) && wdog_nmi_mode_i && !state_q[WDOG_IDX])
    |=> !state_q[WDOG_IDX]); // R8
  AST_HALT_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && dbg_en) |-> (&freeze_o)); // R6
  AST_NO_HALT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_i |-> (freeze_o == state_q)); // R10
  AST_READ_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_i && (addr_i == ADDR_W'(SET_OFS) || addr_i == ADDR_W'(CLR_OFS)))
    |-> (rdata_o == DATA_W'(freeze_o))); // R4
endmodule

// File: tb/frz_ctrl_test.sv
module frz_ctrl_test;
  typedef struct packed {
    logic        wr;
    logic [3:0]  addr;
    logic [15:0] wdata;
    logic        halt;
    logic        nmi;
    logic [4:0]  efrz;
    logic [15:0] erd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'h0, 16'h0003, 1'b0, 1'b0, 5'h03, 16'h0003, 4'd2},  // R2 set two bits
    '{1'b1, 4'h0, 16'h0000, 1'b0, 1'b0, 5'h03, 16'h0003, 4'd2},  // R2 zeros ignored
    '{1'b1, 4'h2, 16'h0001, 1'b0, 1'b0, 5'h02, 16'h0002, 4'd3},  // R3 clear one bit
    '{1'b1, 4'h2, 16'h0000, 1'b0, 1'b0, 5'h02, 16'h0002, 4'd3},  // R3 zeros ignored
    '{1'b1, 4'h0, 16'hFFFC, 1'b0, 1'b1, 5'h16, 16'h0016, 4'd8},  // R8 wdog blocked, R4 upper 0
    '{1'b1, 4'h0, 16'h0008, 1'b0, 1'b0, 5'h1E, 16'h001E, 4'd8},  // R8 wdog allowed
    '{1'b0, 4'h0, 16'h0000, 1'b1, 1'b0, 5'h1F, 16'h001E, 4'd6},  // R6 halt all
    '{1'b1, 4'h4, 16'h0000, 1'b1, 1'b0, 5'h1E, 16'h0000, 4'd5},  // R5 dbg enable off
    '{1'b1, 4'h2, 16'h0008, 1'b1, 1'b0, 5'h1E, 16'h0016, 4'd7},  // R7 wdog forced
    '{1'b0, 4'h2, 16'h0000, 1'b0, 1'b0, 5'h16, 16'h0016, 4'd10}, // R10 halt released
    '{1'b1, 4'h2, 16'hFFFF, 1'b0, 1'b0, 5'h00, 16'h0000, 4'd3},  // R3 clear all
    '{1'b0, 4'h0, 16'h0000, 1'b1, 1'b0, 5'h08, 16'h0000, 4'd7},  // R7 only wdog
    '{1'b1, 4'h4, 16'h0001, 1'b1, 1'b0, 5'h1F, 16'h0001, 4'd6},  // R6 dbg enable back on
    '{1'b1, 4'h6, 16'h0001, 1'b0, 1'b0, 5'h00, 16'h0000, 4'd4},  // R4 unmapped offset
    '{1'b1, 4'h0, 16'h0010, 1'b0, 1'b0, 5'h10, 16'h0010, 4'd1},  // R1 DMA bit 4
    '{1'b1, 4'h2, 16'h0010, 1'b0, 1'b0, 5'h00, 16'h0000, 4'd1}   // R1 DMA release
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        halt = 1'b0;
  logic        nmi = 1'b0;
  logic [4:0]  frz;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  frz_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .halt_i(halt), .wdog_nmi_mode_i(nmi), .freeze_o(frz)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [3:0] a, input logic [15:0] d,
                      input logic h, input logic m);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; halt = h; nmi = m;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    step(1'b0, 4'h0, 16'h0, 1'b0, 1'b0);
    check("R9 freeze after reset", 16'(frz), 16'h0000);
    check("R9 read after reset", rdata, 16'h0000);
    step(1'b0, 4'h4, 16'h0, 1'b0, 1'b0);
    check("R5 dbg enable reset value", rdata, 16'h0001);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].halt, VECS[i].nmi);
      check($sformatf("R%0d vec %0d freeze", VECS[i].req, i), 16'(frz), 16'(VECS[i].efrz));
      check($sformatf("R%0d vec %0d rdata", VECS[i].req, i), rdata, VECS[i].erd);
    end

    // R1 each agent bit alone
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 4'h0, 16'(1 << i), 1'b0, 1'b0);
      check($sformatf("R1 agent %0d set", i), 16'(frz), 16'(1 << i));
      step(1'b1, 4'h2, 16'(1 << i), 1'b0, 1'b0);
      check($sformatf("R1 agent %0d clear", i), 16'(frz), 16'h0000);
    end

    // R9 reset while frozen, R5 dbg enable returns to 1
    step(1'b1, 4'h0, 16'h001F, 1'b0, 1'b0);
    step(1'b1, 4'h4, 16'h0000, 1'b0, 1'b0);
    check("R9 all frozen before reset", 16'(frz), 16'h001F);
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 4'h0, 16'h0, 1'b0, 1'b0);
    check("R9 freeze cleared by reset", 16'(frz), 16'h0000);
    step(1'b0, 4'h4, 16'h0, 1'b0, 1'b0);
    check("R5 dbg enable restored by reset", rdata, 16'h0001);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule